// File: doc/BRIEF.md
# I2C Target Controller with Host Byte Handshake

This block answers as a target on a two-wire I2C bus. It watches SCL and SDA through open-drain pads, recognises START and STOP, compares the 7-bit address that follows a START against a programmable own address, and acknowledges a match. After the match the host moves one byte at a time through a single data register. On a master write, each received byte raises a data-received event. On a master read, the host supplies each byte in turn, prompted by a data-empty event. In buffered mode the block holds SCL low while such an event waits for the host.

Events collect in a status register and stay there until the host writes a zero to them. An enable register with the same bit layout selects which events drive the single interrupt line. Two further controls are available: answering the general-call address, and forcing a NACK on received data bytes. A read-only direction flag in the status register tells the host whether the last matched address asked for a read or a write.

Top module: `i2c_target_ctrl`

## Requirements
- R1: Register offsets on `bus_addr` are 0 control, 1 status, 2 event enable, 3 own address, 4 data. After reset, every register reads 0, `irq` is low, and `scl_oe` and `sda_oe` are low.
- R2: With control bit 2 (target enable) set, an address byte whose upper 7 bits equal the nonzero own address is ACKed in the ninth clock. It sets status bit 0 (address matched), and status bit 5 takes the R/W bit (1 = master read).
- R3: An address byte that matches neither the own address nor an enabled general call gets no ACK and sets no status bit.
- R4: With control bit 1 set, the address byte 0x00 is ACKed and sets status bits 6 and 0 together. With control bit 1 clear, the same byte is not ACKed.
- R5: During a master write, each received byte sets status bit 1 and is readable at data offset 4. It is ACKed while control bit 0 is clear.
- R6: With control bit 0 (forced NACK) set, a received data byte is answered with NACK.
- R7: During a master read, the byte written to data offset 4 is shifted out MSB first. Status bit 3 (data empty) is set after the read-address ACK and after every master ACK. Status bit 2 is set when a byte has been sent.
- R8: A STOP sets status bit 4 only if the block was addressed since the last START.
- R9: Writing a status bit as 0 clears it, and writing it as 1 leaves it unchanged. Status bit 5 is read-only and is not changed by status writes.
- R10: `irq` is the OR of status AND enable over every bit except bit 5, which never raises `irq`.
- R11: With control bit 3 (buffered mode) set, `scl_oe` is held high from the event that sets status bit 1 or 3 until the host reads or writes data offset 4. With control bit 3 clear, SCL is never held.
- R12: With control bit 2 clear, the block drives neither line and ACKs no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on data offset) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
If the bit counter or link state goes wrong, the ACK lands in the wrong clock. That shows on SDA at the ninth SCL high of the same byte, and the bench samples the ACK there. If the hold flag is wrong, SCL either stays low past a data access, which stalls the bus master at once, or it is never held. Both cases show on `scl_oe` a few clocks after the eighth falling edge. Wrong status bookkeeping shows on the next status read and on `irq` one clock after the event or the write.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  localparam int REG_AW  = 3;
  localparam int BYTE_W  = 8;
  localparam int TADDR_W = 7;
  localparam int EV_W    = 7;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
  localparam logic [REG_AW-1:0] RA_IEN  = 3'd2;
  localparam logic [REG_AW-1:0] RA_OWN  = 3'd3;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd4;

  localparam int CB_FNA  = 0;
  localparam int CB_GCEN = 1;
  localparam int CB_EN   = 2;
  localparam int CB_BUF  = 3;
  localparam int CTRL_W  = 4;

  localparam int EB_ADR = 0;
  localparam int EB_RXF = 1;
  localparam int EB_TXD = 2;
  localparam int EB_TXE = 3;
  localparam int EB_STP = 4;
  localparam int EB_DIR = 5;
  localparam int EB_GC  = 6;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_AACK, LS_RX, LS_DACK, LS_TX, LS_TACK
  } link_st_e;
endpackage

// File: rtl/i2ct_sync.sv
`timescale 1ns/1ps
module i2ct_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
`timescale 1ns/1ps
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2ct_link.sv
`timescale 1ns/1ps
module i2ct_link
  import i2ct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               gc_en,
  input  logic               fna,
  input  logic               buf_mode,
  input  logic [TADDR_W-1:0] own_addr,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_c,
  input  logic               stop_c,
  input  logic               sda_s,
  input  logic               tx_load,
  input  logic [BYTE_W-1:0]  tx_byte,
  input  logic               rx_take,
  output logic               sda_oe,
  output logic               scl_oe,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic [EV_W-1:0]    ev
);
  link_st_e          st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, txsh, txsh_n, rxb, rxb_n;
  logic              ack_drv, ack_n, hold, hold_n, addressed, adr_n;
  logic              dir, dir_n, m_ack, mack_n;
  logic [EV_W-1:0]   ev_n;
  logic              hit_own, hit_gc;

  assign hit_own = (sh[BYTE_W-1:1] == own_addr) && (sh[BYTE_W-1:1] != '0);
  assign hit_gc  = gc_en && (sh == '0);

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; txsh_n = txsh; rxb_n = rxb;
    ack_n = ack_drv; hold_n = hold; adr_n = addressed; dir_n = dir;
    mack_n = m_ack; ev_n = '0;
    if (tx_load) begin txsh_n = tx_byte; hold_n = 1'b0; end
    if (rx_take) hold_n = 1'b0;
    if (!buf_mode) hold_n = 1'b0;
    if (!enable) begin
      st_n = LS_IDLE; ack_n = 1'b0; hold_n = 1'b0; adr_n = 1'b0;
    end else if (start_c) begin
      st_n = LS_ADDR; cnt_n = '0; ack_n = 1'b0; hold_n = 1'b0; adr_n = 1'b0;
    end else if (stop_c) begin
      st_n = LS_IDLE; ack_n = 1'b0; hold_n = 1'b0; adr_n = 1'b0;
      ev_n[EB_STP] = addressed;
    end else begin
      unique case (st)
        LS_ADDR, LS_RX: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
            if (st == LS_RX) begin
              rxb_n = sh; ev_n[EB_RXF] = 1'b1; hold_n = buf_mode;
              ack_n = ~fna; st_n = LS_DACK;
            end else if (hit_own || hit_gc) begin
              st_n = LS_AACK; ack_n = 1'b1; adr_n = 1'b1;
              ev_n[EB_ADR] = 1'b1; ev_n[EB_GC] = hit_gc;
              ev_n[EB_DIR] = sh[0]; dir_n = sh[0];
            end else begin
              st_n = LS_IDLE;
            end
          end
        end
        LS_AACK: if (scl_fall) begin
          ack_n = 1'b0; cnt_n = '0;
          if (dir) begin
            st_n = LS_TX; ev_n[EB_TXE] = 1'b1; hold_n = buf_mode;
          end else begin
            st_n = LS_RX;
          end
        end
        LS_DACK: if (scl_fall) begin
          ack_n = 1'b0; cnt_n = '0; st_n = LS_RX;
        end
        LS_TX: if (scl_fall) begin
          txsh_n = {txsh[BYTE_W-2:0], 1'b1};
          cnt_n  = cnt + 1'b1;
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            st_n = LS_TACK; ev_n[EB_TXD] = 1'b1;
          end
        end
        LS_TACK: begin
          if (scl_rise) mack_n = ~sda_s;
          else if (scl_fall) begin
            cnt_n = '0;
            if (m_ack) begin
              st_n = LS_TX; ev_n[EB_TXE] = 1'b1; hold_n = buf_mode;
            end else begin
              st_n = LS_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LS_IDLE; cnt <= '0; sh <= '0; txsh <= '1; rxb <= '0;
      ack_drv <= 1'b0; hold <= 1'b0; addressed <= 1'b0; dir <= 1'b0;
      m_ack <= 1'b0; ev <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; txsh <= txsh_n; rxb <= rxb_n;
      ack_drv <= ack_n; hold <= hold_n; addressed <= adr_n; dir <= dir_n;
      m_ack <= mack_n; ev <= ev_n;
    end
  end

  assign sda_oe  = ack_drv | ((st == LS_TX) & ~txsh[BYTE_W-1]);
  assign scl_oe  = hold;
  assign rx_byte = rxb;

  p_quiet_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sda_oe && !scl_oe));
  p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_AACK) |-> addressed);
  p_hold_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_take || tx_load) && !scl_fall) |=> !scl_oe);
endmodule

// File: rtl/i2c_target_ctrl.sv
`timescale 1ns/1ps
module i2c_target_ctrl
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);
  localparam logic [EV_W-1:0] DIR_M = EV_W'(1 << EB_DIR);

  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic [1:0] pins_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_i), .d({scl_i, sda_i}), .q(pins_s));
  i2ct_cond u_cond (
    .clk(clk), .rst_n(rst_i), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c));

  logic [CTRL_W-1:0]  ctrl, ctrl_n;
  logic [EV_W-1:0]    stat, stat_n, ien, ien_n, ev;
  logic [TADDR_W-1:0] own, own_n;
  logic [BYTE_W-1:0]  rx_byte;
  logic wr_ctrl, wr_stat, wr_ien, wr_own, wr_data, rd_data;

  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_stat = bus_wr && (bus_addr == RA_STAT);
  assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
  assign wr_own  = bus_wr && (bus_addr == RA_OWN);
  assign wr_data = bus_wr && (bus_addr == RA_DATA);
  assign rd_data = bus_rd && (bus_addr == RA_DATA);

  i2ct_link u_link (
    .clk(clk), .rst_n(rst_i),
    .enable(ctrl[CB_EN]), .gc_en(ctrl[CB_GCEN]), .fna(ctrl[CB_FNA]),
    .buf_mode(ctrl[CB_BUF]), .own_addr(own),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
    .sda_s(pins_s[0]), .tx_load(wr_data), .tx_byte(bus_wdata), .rx_take(rd_data),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .rx_byte(rx_byte), .ev(ev));

  always_comb begin
    ctrl_n = wr_ctrl ? bus_wdata[CTRL_W-1:0]  : ctrl;
    ien_n  = wr_ien  ? bus_wdata[EV_W-1:0]    : ien;
    own_n  = wr_own  ? bus_wdata[TADDR_W-1:0] : own;
    stat_n = stat;
    if (wr_stat) stat_n = stat & (bus_wdata[EV_W-1:0] | DIR_M);
    stat_n = stat_n | (ev & ~DIR_M);
    if (ev[EB_ADR]) stat_n[EB_DIR] = ev[EB_DIR];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl <= '0; stat <= '0; ien <= '0; own <= '0;
    end else begin
      ctrl <= ctrl_n; stat <= stat_n; ien <= ien_n; own <= own_n;
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_CTRL: bus_rdata = BYTE_W'(ctrl);
      RA_STAT: bus_rdata = BYTE_W'(stat);
      RA_IEN:  bus_rdata = BYTE_W'(ien);
      RA_OWN:  bus_rdata = BYTE_W'(own);
      RA_DATA: bus_rdata = rx_byte;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(stat & ien & ~DIR_M);

  p_zero_clears_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_stat && !bus_wdata[EB_ADR] && !ev[EB_ADR]) |=> !stat[EB_ADR]);
  p_dir_read_only_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_stat && !ev[EB_ADR]) |=> (stat[EB_DIR] == $past(stat[EB_DIR])));
  p_gc_with_match_r4: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(stat[EB_GC]) |-> stat[EB_ADR]);
endmodule

// File: tb/i2c_target_ctrl_test.sv
`timescale 1ns/1ps
module i2c_target_ctrl_test;
  localparam int Q = 25;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2,
                         A_OWN = 3'd3, A_DATA = 3'd4;
  // {own[24:18], gc_en[17], target[16:10], data[9:2], fna[1], expect_ack[0]}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {7'h3C, 1'b0, 7'h3C, 8'hA5, 1'b0, 1'b1},
    {7'h3C, 1'b0, 7'h3D, 8'h11, 1'b0, 1'b0},
    {7'h51, 1'b1, 7'h00, 8'h7E, 1'b0, 1'b1},
    {7'h51, 1'b0, 7'h00, 8'h22, 1'b0, 1'b0},
    {7'h12, 1'b0, 7'h12, 8'h00, 1'b1, 1'b1},
    {7'h7F, 1'b0, 7'h7F, 8'hFF, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic scl_oe, sda_oe, irq;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  wire  scl_line = !(m_scl_lo || scl_oe);
  wire  sda_line = !(m_sda_lo || sda_oe);
  int   n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_target_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic scl_up();
    m_scl_lo = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask
  task automatic m_start();
    m_sda_lo = 1'b0; m_scl_lo = 1'b0; wq; m_sda_lo = 1'b1; wq; m_scl_lo = 1'b1; wq;
  endtask
  task automatic m_stop();
    m_sda_lo = 1'b1; wq; scl_up; wq; m_sda_lo = 1'b0; wq;
  endtask
  task automatic m_bit_out(input logic b);
    m_sda_lo = !b; wq; scl_up; wq; m_scl_lo = 1'b1; wq;
  endtask
  task automatic m_bit_in(output logic b);
    m_sda_lo = 1'b0; wq; scl_up; wq; b = sda_line; m_scl_lo = 1'b1; wq;
  endtask
  task automatic m_byte_out(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
  endtask
  task automatic m_byte_in(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      m_bit_in(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all R): actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r, b8;
    logic a;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 5; k++) begin
      reg_rd(3'(k), r);
      check("R1 register reset", r, 8'h00);
    end
    check("R1 irq reset", irq, 1'b0);
    check("R1 lines released", {scl_oe, sda_oe}, 2'b00);

    // Vector table: master write transactions
    for (int v = 0; v < NV; v++) begin
      logic [6:0] own_a, tgt;
      logic [7:0] dat;
      logic gc, fn, exp_ack;
      {own_a, gc, tgt, dat, fn, exp_ack} = VEC[v];
      reg_wr(A_OWN, {1'b0, own_a});
      reg_wr(A_CTRL, {4'b0, 1'b1, 1'b1, gc, fn});
      reg_wr(A_STAT, 8'h00);
      reg_wr(A_IEN, 8'h7F);
      m_start;
      m_byte_out({tgt, 1'b0});
      m_bit_in(a);
      check("R2/R3/R4 address ack", !a, exp_ack);
      if (exp_ack) begin
        reg_rd(A_STAT, r);
        check("R2/R4 match status", r, (tgt == 7'h00) ? 8'h41 : 8'h01);
        check("R10 irq on match", irq, 1'b1);
        reg_wr(A_STAT, 8'h00);
        m_byte_out(dat);
        repeat (5) @(negedge clk);
        check("R11 scl held on received byte", scl_oe, 1'b1);
        reg_rd(A_STAT, r);
        check("R5 data received flag", r, 8'h02);
        reg_rd(A_DATA, r);
        check("R5 received byte", r, dat);
        check("R11 scl released after read", scl_oe, 1'b0);
        m_bit_in(a);
        check("R5/R6 data ack vs forced nack", a, fn);
        m_stop;
        repeat (5) @(negedge clk);
        reg_rd(A_STAT, r);
        check("R8 stop flag when addressed", r[4], 1'b1);
      end else begin
        m_stop;
        repeat (5) @(negedge clk);
        reg_rd(A_STAT, r);
        check("R3/R8 no status on mismatch", r, 8'h00);
        check("R3 irq quiet", irq, 1'b0);
      end
    end

    // R7 master read with buffered handshake
    reg_wr(A_OWN, 8'h3C);
    reg_wr(A_CTRL, 8'h0C);
    reg_wr(A_STAT, 8'h00);
    reg_wr(A_IEN, 8'h08);
    m_start;
    m_byte_out({7'h3C, 1'b1});
    m_bit_in(a);
    check("R2 read address ack", a, 1'b0);
    reg_rd(A_STAT, r);
    check("R2/R7 match, direction, data empty", r, 8'h29);
    check("R11 scl held for data empty", scl_oe, 1'b1);
    check("R10 irq from data empty", irq, 1'b1);
    reg_wr(A_STAT, 8'hF7);
    check("R9 zero clears bit 3 irq", irq, 1'b0);
    reg_rd(A_STAT, r);
    check("R9 only bit 3 cleared", r, 8'h21);
    reg_wr(A_DATA, 8'hA5);
    check("R11 scl released after write", scl_oe, 1'b0);
    m_byte_in(b8);
    check("R7 first byte out", b8, 8'hA5);
    m_bit_out(1'b0);
    reg_rd(A_STAT, r);
    check("R7 sent and empty flags", r & 8'h0C, 8'h0C);
    reg_wr(A_STAT, 8'h00);
    reg_rd(A_STAT, r);
    check("R9 direction bit read-only", r, 8'h20);
    reg_wr(A_DATA, 8'h5A);
    m_byte_in(b8);
    check("R7 second byte out", b8, 8'h5A);
    m_bit_out(1'b1);
    m_stop;
    repeat (5) @(negedge clk);
    reg_rd(A_STAT, r);
    check("R8 stop after read", r, 8'h34);
    check("R7 no data empty after master nack", r[3], 1'b0);

    // R9 write-one keeps, R10 masking
    reg_wr(A_STAT, 8'hFF);
    reg_rd(A_STAT, r);
    check("R9 writing ones keeps bits", r, 8'h34);
    reg_wr(A_IEN, 8'h20);
    check("R10 direction bit raises no irq", irq, 1'b0);
    reg_wr(A_IEN, 8'h10);
    check("R10 stop enabled raises irq", irq, 1'b1);
    reg_wr(A_IEN, 8'h00);
    check("R10 all masked", irq, 1'b0);

    // R11 unbuffered mode: no clock hold
    reg_wr(A_CTRL, 8'h04);
    reg_wr(A_STAT, 8'h00);
    m_start;
    m_byte_out({7'h3C, 1'b0});
    m_bit_in(a);
    m_byte_out(8'hC3);
    repeat (5) @(negedge clk);
    check("R11 no hold in unbuffered mode", scl_oe, 1'b0);
    reg_rd(A_DATA, r);
    check("R5 unbuffered byte", r, 8'hC3);
    m_bit_in(a);
    check("R5 unbuffered ack", a, 1'b0);
    m_stop;

    // R12 disabled target ignores its address
    reg_wr(A_CTRL, 8'h08);
    reg_wr(A_STAT, 8'h00);
    m_start;
    m_byte_out({7'h3C, 1'b0});
    m_bit_in(a);
    check("R12 no ack when disabled", a, 1'b1);
    m_stop;
    repeat (5) @(negedge clk);
    reg_rd(A_STAT, r);
    check("R12 no status when disabled", r, 8'h00);
    check("R12 lines released", {scl_oe, sda_oe}, 2'b00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule